// File: doc/BRIEF.md
# Free-Running Wide Counter with Torn-Read Detection

This block keeps a wide cycle counter that software reads through a narrow register port, one half at a time. Because the two halves are fetched in separate accesses, the pair can tear. The upper half may step between the two fetches, or an interrupt handler may run in the gap and leave the halves far apart in time. A small tracker follows each readout. Software reads the low half, then the high half, then the control register. Bit 31 of the control value shows whether the pair just fetched belongs together. If it does not, software repeats the three reads.

Read data is combinational from the address and the read strobe, so it is valid in the same cycle as the access. Every side effect of an access (tracker moves, enable changes) takes effect on the clock edge that ends that cycle. The half width is a parameter. The counter is always two halves wide, and halves narrower than the data bus are zero-extended.

Top module: `wide_tick_counter`

## Requirements
- R1: After reset the counter is zero, counting is disabled and a control read returns 0 (status bit 31 = 0, enable bit 0 = 0).
- R2: A write to the control address (0x103) loads the enable from write-data bit 0. While it is 1 the counter advances by one every cycle, and while it is 0 the counter holds. Control reads return the enable in bit 0 and zero in bits 30..1.
- R3: A read of 0x104 returns the lower half of the counter and a read of 0x105 the upper half, both zero-extended to the bus. The full counter wraps to zero after its all-ones value.
- R4: A read of 0x104, then a read of 0x105, then a control read, with no qualifying exception or upper-half step in between, returns status bit 31 = 1. Idle cycles may separate the three reads.
- R5: If the exception input is high in any cycle from the low-half read up to and including the high-half read, the following control read returns status 0.
- R6: If the upper half increments on any clock edge from the one ending the low-half read up to the one before the control read, that control read returns status 0.
- R7: A control read returns status 0 unless the last tracked reads were one low-half read followed by exactly one high-half read. A control read ends the sequence, so a second consecutive control read returns status 0.
- R8: A low-half read always starts a fresh sequence and discards any earlier failure.
- R9: Writes to 0x104 or 0x105 do not change the counter. Reads of any address other than 0x103..0x105 return 0 and do not change the tracker.
- R10: The exception input has no effect on status before the low-half read or after the high-half read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_addr | input | ADDR_W | Register address |
| acc_rd | input | 1 | Read strobe, one cycle per access |
| acc_wr | input | 1 | Write strobe, one cycle per access |
| acc_wdata | input | DATA_W | Write data |
| acc_rdata | output | DATA_W | Read data, valid in the strobe cycle |
| exc_taken | input | 1 | High in a cycle in which an interrupt or exception is taken |

## Verification
Read data is due in the same cycle as the read strobe, so the bench drives each access just after a falling edge and samples one nanosecond later, before the rising edge. Each access then moves the bench's own model across that edge. A count enable written in one cycle therefore shows up in the half values read one cycle later. An exception or carry in the cycle just before the control read shows up in that read's status. The upper-half carry is reached quickly by building the bench with 8-bit halves, so wraps fall at known points, both in the directed cases and under random traffic.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

   // Readout tracker position within a low/high/control sequence
   typedef enum logic [1:0] {
      TRK_IDLE = 2'd0,
      TRK_LOW  = 2'd1,
      TRK_HIGH = 2'd2
   } trk_state_e;

   // Decoded register access for one cycle
   typedef struct packed {
      logic rd_lo;
      logic rd_hi;
      logic rd_ctrl;
      logic wr_ctrl;
      logic rd_other;
   } wtc_access_t;

endpackage

// File: rtl/wtc_counter.sv
module wtc_counter #(
   parameter int WORD_W = 32,
   parameter int NWORDS = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en,
   output logic [NWORDS*WORD_W-1:0] cnt,
   output logic                     lo_carry
);
   localparam logic [WORD_W-1:0] W_ONE = WORD_W'(1);

   // inc[w] is the increment request arriving at word w
   logic [NWORDS-1:0] inc;
   assign inc[0] = en;

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      logic [WORD_W-1:0] word_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      word_q <= '0;
         else if (inc[w]) word_q <= word_q + W_ONE;
      end

      assign cnt[w*WORD_W +: WORD_W] = word_q;

      if (w < NWORDS - 1) begin : g_chain
         assign inc[w+1] = inc[w] & (&word_q);
      end
   end

   // Carry out of the lowest word: the upper half steps on this edge
   if (NWORDS > 1) begin : g_carry
      assign lo_carry = inc[1];
   end else begin : g_nocarry
      assign lo_carry = 1'b0;
   end
endmodule

// File: rtl/wtc_regmap.sv
module wtc_regmap
   import wtc_pkg::*;
#(
   parameter int              ADDR_W    = 12,
   parameter int              DATA_W    = 32,
   parameter int              WORD_W    = 32,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'('h103),
   parameter logic [ADDR_W-1:0] LO_ADDR   = ADDR_W'('h104),
   parameter logic [ADDR_W-1:0] HI_ADDR   = ADDR_W'('h105)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   acc_addr,
   input  logic                acc_rd,
   input  logic                acc_wr,
   input  logic [DATA_W-1:0]   acc_wdata,
   input  logic [2*WORD_W-1:0] cnt,
   input  logic                status_ok,
   output wtc_access_t         acc,
   output logic                en_q,
   output logic [DATA_W-1:0]   rdata
);
   localparam int STATUS_BIT = DATA_W - 1;

   logic hit_ctrl, hit_lo, hit_hi;
   logic unused_wdata;

   assign hit_ctrl = (acc_addr == CTRL_ADDR);
   assign hit_lo   = (acc_addr == LO_ADDR);
   assign hit_hi   = (acc_addr == HI_ADDR);

   assign acc.rd_lo    = acc_rd & hit_lo;
   assign acc.rd_hi    = acc_rd & hit_hi;
   assign acc.rd_ctrl  = acc_rd & hit_ctrl;
   assign acc.wr_ctrl  = acc_wr & hit_ctrl;
   assign acc.rd_other = acc_rd & ~(hit_ctrl | hit_lo | hit_hi);

   assign unused_wdata = ^acc_wdata[DATA_W-1:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          en_q <= 1'b0;
      else if (acc.wr_ctrl) en_q <= acc_wdata[0];
   end

   always_comb begin
      rdata = '0;
      if (acc.rd_ctrl) begin
         rdata[STATUS_BIT] = status_ok;
         rdata[0]          = en_q;
      end else if (acc.rd_lo) begin
         rdata = DATA_W'(cnt[WORD_W-1:0]);
      end else if (acc.rd_hi) begin
         rdata = DATA_W'(cnt[2*WORD_W-1:WORD_W]);
      end
   end
endmodule

// File: rtl/wtc_tracker.sv
module wtc_tracker
   import wtc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  wtc_access_t acc,
   input  logic        exc,
   input  logic        carry,
   output trk_state_e  state_q,
   output logic        ok_q,
   output logic        status_ok
);
   trk_state_e state_d;
   logic       ok_d;

   always_comb begin
      state_d = state_q;
      ok_d    = ok_q;
      if (acc.rd_lo) begin
         // fresh sequence; a carry or exception on this edge already spoils it
         state_d = TRK_LOW;
         ok_d    = ~(carry | exc);
      end else if (acc.rd_hi) begin
         if (state_q == TRK_LOW) begin
            state_d = TRK_HIGH;
            ok_d    = ok_q & ~carry & ~exc;
         end else begin
            state_d = TRK_IDLE;
            ok_d    = 1'b0;
         end
      end else if (acc.rd_ctrl) begin
         state_d = TRK_IDLE;
         ok_d    = 1'b0;
      end else begin
         unique case (state_q)
            TRK_LOW:  ok_d = ok_q & ~carry & ~exc;
            TRK_HIGH: ok_d = ok_q & ~carry;
            default:  ok_d = ok_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TRK_IDLE;
         ok_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         ok_q    <= ok_d;
      end
   end

   assign status_ok = (state_q == TRK_HIGH) & ok_q;
endmodule

// File: rtl/wide_tick_counter.sv
module wide_tick_counter
   import wtc_pkg::*;
#(
   parameter int              ADDR_W    = 12,
   parameter int              DATA_W    = 32,
   parameter int              WORD_W    = 32,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'('h103),
   parameter logic [ADDR_W-1:0] LO_ADDR   = ADDR_W'('h104),
   parameter logic [ADDR_W-1:0] HI_ADDR   = ADDR_W'('h105)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_rd,
   input  logic              acc_wr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   input  logic              exc_taken
);
   localparam int NWORDS = 2;
   localparam int CNT_W  = NWORDS * WORD_W;

   if (WORD_W < 1 || WORD_W > DATA_W) begin : g_bad_word
      $error("wide_tick_counter: WORD_W must be between 1 and DATA_W");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("wide_tick_counter: DATA_W must leave room for status and enable");
   end
   if (CTRL_ADDR == LO_ADDR || CTRL_ADDR == HI_ADDR || LO_ADDR == HI_ADDR) begin : g_bad_map
      $error("wide_tick_counter: register addresses must be distinct");
   end

   wtc_access_t      acc;
   logic             en_q;
   logic [CNT_W-1:0] cnt_q;
   logic             lo_carry;
   trk_state_e       trk_state;
   logic             trk_ok;
   logic             status_ok;

   wtc_counter #(
      .WORD_W (WORD_W),
      .NWORDS (NWORDS)
   ) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_q),
      .cnt      (cnt_q),
      .lo_carry (lo_carry)
   );

   wtc_regmap #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .WORD_W    (WORD_W),
      .CTRL_ADDR (CTRL_ADDR),
      .LO_ADDR   (LO_ADDR),
      .HI_ADDR   (HI_ADDR)
   ) u_regmap (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_addr  (acc_addr),
      .acc_rd    (acc_rd),
      .acc_wr    (acc_wr),
      .acc_wdata (acc_wdata),
      .cnt       (cnt_q),
      .status_ok (status_ok),
      .acc       (acc),
      .en_q      (en_q),
      .rdata     (acc_rdata)
   );

   wtc_tracker u_tracker (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc       (acc),
      .exc       (exc_taken),
      .carry     (lo_carry),
      .state_q   (trk_state),
      .ok_q      (trk_ok),
      .status_ok (status_ok)
   );
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker
   import wtc_pkg::*;
#(
   parameter int              ADDR_W    = 12,
   parameter int              DATA_W    = 32,
   parameter int              WORD_W    = 32,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'('h103),
   parameter logic [ADDR_W-1:0] LO_ADDR   = ADDR_W'('h104),
   parameter logic [ADDR_W-1:0] HI_ADDR   = ADDR_W'('h105)
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   acc_addr,
   input logic                acc_rd,
   input logic [DATA_W-1:0]   acc_rdata,
   input logic                exc_taken,
   input logic                en_q,
   input logic [2*WORD_W-1:0] cnt_q,
   input trk_state_e          trk_state,
   input logic                trk_ok
);
   localparam logic [2*WORD_W-1:0] C_ONE = (2*WORD_W)'(1);

   logic rd_lo, rd_ctrl, rd_other, lo_wrap;
   assign rd_lo    = acc_rd && (acc_addr == LO_ADDR);
   assign rd_ctrl  = acc_rd && (acc_addr == CTRL_ADDR);
   assign rd_other = acc_rd && (acc_addr != LO_ADDR) && (acc_addr != HI_ADDR)
                     && (acc_addr != CTRL_ADDR);
   assign lo_wrap  = en_q && (&cnt_q[WORD_W-1:0]);

   a_r2_count_advances: assert property (@(posedge clk) disable iff (!rst_n)
      $past(en_q) |-> cnt_q == $past(cnt_q) + C_ONE);

   a_r2_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en_q) |-> $stable(cnt_q));

   a_r4_clean_status: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ctrl && trk_state == TRK_HIGH && trk_ok) |-> acc_rdata[DATA_W-1]);

   a_r5_exc_voids: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_taken && (trk_state == TRK_LOW || rd_lo)) |=> !trk_ok);

   a_r6_carry_voids: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_wrap && (trk_state != TRK_IDLE || rd_lo)) |=> !trk_ok);

   a_r7_unpaired_ctrl_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ctrl && trk_state != TRK_HIGH) |-> !acc_rdata[DATA_W-1]);

   a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_other |-> acc_rdata == '0);
endmodule

bind wide_tick_counter wtc_checker #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .WORD_W    (WORD_W),
   .CTRL_ADDR (CTRL_ADDR),
   .LO_ADDR   (LO_ADDR),
   .HI_ADDR   (HI_ADDR)
) u_wtc_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_addr  (acc_addr),
   .acc_rd    (acc_rd),
   .acc_rdata (acc_rdata),
   .exc_taken (exc_taken),
   .en_q      (en_q),
   .cnt_q     (cnt_q),
   .trk_state (trk_state),
   .trk_ok    (trk_ok)
);

// File: tb/test_wide_tick_counter.sv
module test_wide_tick_counter;
   localparam logic [11:0] A_CTRL = 12'h103;
   localparam logic [11:0] A_LO   = 12'h104;
   localparam logic [11:0] A_HI   = 12'h105;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] acc_addr = '0;
   logic        acc_rd = 1'b0;
   logic        acc_wr = 1'b0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] acc_rdata;
   logic        exc_taken = 1'b0;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   // bench model, built from the requirements (8-bit halves)
   logic [15:0] m_cnt = '0;
   bit          m_en  = 1'b0;
   int          m_st  = 0;      // 0 idle, 1 low read, 2 high read
   bit          m_ok  = 1'b0;
   string       m_why = "R7";

   always #2 clk = ~clk;       // 250 MHz

   wide_tick_counter #(.ADDR_W(12), .DATA_W(32), .WORD_W(8)) i_wide_tick_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_addr  (acc_addr),
      .acc_rd    (acc_rd),
      .acc_wr    (acc_wr),
      .acc_wdata (acc_wdata),
      .acc_rdata (acc_rdata),
      .exc_taken (exc_taken)
   );

   function automatic logic [31:0] exp_rdata(logic [11:0] a);
      case (a)
         A_CTRL:  return {(m_st == 2) && m_ok, 30'b0, m_en};
         A_LO:    return {24'b0, m_cnt[7:0]};
         A_HI:    return {24'b0, m_cnt[15:8]};
         default: return 32'b0;
      endcase
   endfunction

   task automatic kill(string why);
      if (m_ok) m_why = why;
      m_ok = 1'b0;
   endtask

   task automatic model_step(bit rd, bit wr, logic [11:0] a, logic [31:0] wd, bit exc);
      bit carry;
      carry = m_en && (m_cnt[7:0] == 8'hFF);
      if (rd && a == A_LO) begin
         m_st = 1; m_ok = 1'b1; m_why = "R7";
         if (exc) kill("R5"); else if (carry) kill("R6");
      end else if (rd && a == A_HI) begin
         if (m_st == 1) begin
            m_st = 2;
            if (exc) kill("R5"); else if (carry) kill("R6");
         end else begin
            m_st = 0; kill("R7");
         end
      end else if (rd && a == A_CTRL) begin
         m_st = 0; m_ok = 1'b0; m_why = "R7";
      end else if (m_st == 1) begin
         if (exc) kill("R5"); else if (carry) kill("R6");
      end else if (m_st == 2) begin
         if (carry) kill("R6");
      end
      if (m_en) m_cnt = m_cnt + 16'd1;
      if (wr && a == A_CTRL) m_en = wd[0];
   endtask

   // one bus cycle: drive after a falling edge, sample before the rising edge
   task automatic cyc1(bit rd, bit wr, logic [11:0] a, logic [31:0] wd, bit exc, string tag);
      logic [31:0] exp;
      string       t;
      acc_rd = rd; acc_wr = wr; acc_addr = a; acc_wdata = wd; exc_taken = exc;
      #1;
      if (rd) begin
         exp = exp_rdata(a);
         if (tag != "") t = tag;
         else if (a == A_CTRL) t = exp[31] ? "R4" : m_why;
         else if (a == A_LO || a == A_HI) t = "R3";
         else t = "R9";
         checks++;
         if (acc_rdata !== exp) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", t, a, acc_rdata, exp);
         end
      end
      model_step(rd, wr, a, wd, exc);
      @(negedge clk);
      acc_rd = 1'b0; acc_wr = 1'b0; exc_taken = 1'b0;
   endtask

   task automatic rd1(logic [11:0] a, string tag);
      cyc1(1'b1, 1'b0, a, 32'h0, 1'b0, tag);
   endtask

   task automatic idle(bit exc);
      cyc1(1'b0, 1'b0, A_LO, 32'h0, exc, "");
   endtask

   task automatic wr1(logic [11:0] a, logic [31:0] d);
      cyc1(1'b0, 1'b1, a, d, 1'b0, "");
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 60000 && !done) begin
         done = 1'b1;
         fails++;
         $display("FAIL R2 watchdog actual=%0d cycles expected<=60000", cyc);
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      rd1(A_CTRL, "R1"); rd1(A_LO, "R1"); rd1(A_HI, "R1");
      // R2: disabled counter holds
      idle(0); idle(0); idle(0);
      rd1(A_LO, "R2");
      // R2: enable and watch it advance
      wr1(A_CTRL, 32'hFFFF_FFF1);
      rd1(A_CTRL, "R2"); rd1(A_LO, "R2"); rd1(A_LO, "R2");
      // R4: clean sequence, with and without gaps
      rd1(A_LO, ""); rd1(A_HI, ""); rd1(A_CTRL, "R4");
      rd1(A_LO, ""); idle(0); rd1(A_HI, ""); idle(0); rd1(A_CTRL, "R4");
      // R5: exception between the reads, and on the high read cycle
      rd1(A_LO, ""); idle(1); rd1(A_HI, ""); rd1(A_CTRL, "R5");
      rd1(A_LO, ""); cyc1(1'b1, 1'b0, A_HI, 32'h0, 1'b1, ""); rd1(A_CTRL, "R5");
      // R10: exceptions outside the window
      rd1(A_LO, ""); rd1(A_HI, ""); idle(1); rd1(A_CTRL, "R10");
      idle(1); rd1(A_LO, ""); rd1(A_HI, ""); rd1(A_CTRL, "R10");
      // R7: out-of-order reads
      rd1(A_CTRL, "R7");
      rd1(A_HI, ""); rd1(A_CTRL, "R7");
      rd1(A_LO, ""); rd1(A_HI, ""); rd1(A_HI, ""); rd1(A_CTRL, "R7");
      rd1(A_LO, ""); rd1(A_HI, ""); rd1(A_CTRL, "R4"); rd1(A_CTRL, "R7");
      // R8: restart forgets an earlier failure
      rd1(A_LO, ""); idle(1); rd1(A_LO, ""); rd1(A_HI, ""); rd1(A_CTRL, "R8");
      // R9: writes to half addresses and unmapped reads
      wr1(A_LO, 32'h0000_00AA); wr1(A_HI, 32'h0000_0055);
      rd1(12'h106, "R9"); rd1(12'h000, "R9");
      rd1(A_LO, "R9"); rd1(A_HI, "R9"); rd1(A_CTRL, "R9");
      // R6: upper half steps between the low read and the control read
      while (m_cnt[7:0] != 8'hFC) idle(0);
      rd1(A_LO, ""); idle(0); idle(0); idle(0); rd1(A_HI, ""); rd1(A_CTRL, "R6");
      // R6: carry on the very edge ending the low read
      while (m_cnt[7:0] != 8'hFF) idle(0);
      rd1(A_LO, "R3"); rd1(A_HI, "R3"); rd1(A_CTRL, "R6");
      // R6: carry after the high read, before control
      while (m_cnt[7:0] != 8'hFE) idle(0);
      rd1(A_LO, ""); rd1(A_HI, ""); rd1(A_CTRL, "R6");
      // R2: disable freezes, then re-enable
      wr1(A_CTRL, 32'h0);
      rd1(A_LO, "R2"); rd1(A_LO, "R2"); rd1(A_CTRL, "R2");
      wr1(A_CTRL, 32'h1);

      // random retry loops mixed with stray traffic
      for (int n = 0; n < 500; n++) begin
         int gap;
         gap = $urandom_range(0, 3);
         for (int g = 0; g < gap; g++) idle($urandom_range(0, 9) == 0);
         if ($urandom_range(0, 19) == 0) begin
            case ($urandom_range(0, 3))
               0: rd1(A_HI, "");
               1: rd1(A_CTRL, "");
               2: rd1(12'h0FF, "");
               default: begin wr1(A_CTRL, 32'h0); idle(0); wr1(A_CTRL, 32'h1); end
            endcase
         end
         cyc1(1'b1, 1'b0, A_LO, 32'h0, $urandom_range(0, 9) == 0, "");
         gap = $urandom_range(0, 3);
         for (int g = 0; g < gap; g++) idle($urandom_range(0, 11) == 0);
         cyc1(1'b1, 1'b0, A_HI, 32'h0, $urandom_range(0, 11) == 0, "");
         gap = $urandom_range(0, 2);
         for (int g = 0; g < gap; g++) idle($urandom_range(0, 4) == 0);
         rd1(A_CTRL, "");
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule